// File: doc/BRIEF.md
# Single-Cycle Word Processor Core

This block is a 32-bit processor that finishes every instruction in one clock cycle. It handles a small integer instruction set of seven operations. Three are register-to-register operations: add, subtract and bitwise AND. The other four take a 16-bit immediate: OR-with-immediate, word load, word store and branch-if-equal. The core reads the current instruction from an external instruction memory, addressed by its program counter. It reads two source registers from a 32-entry register file and computes one result. It then updates either a register or the external data memory, and picks the next program counter, all in the same cycle.

The data memory sits outside the core. It must answer reads combinationally from a stable address, and it must take a write on the rising clock edge while the write strobe is high. The instruction memory is also external and is read combinationally. The environment loads register contents by running OR-immediate instructions from register zero.

Top module: `sc_core`

## Requirements
- R1: A synchronous active-high `rst` sampled at a rising edge sets the program counter, seen on `imem_addr`, to 0, and `imem_addr` stays 0 while `rst` is held.
- R2: Every instruction other than a taken branch advances `imem_addr` by 4 at the next rising edge.
- R3: With opcode bits [31:26] = 0x00, funct bits [5:0] = 0x20, 0x22 and 0x24 write rs+rt, rs-rt and rs&rt respectively into the register named by bits [15:11]. The source registers are named by bits [25:21] (rs) and [20:16] (rt).
- R4: Opcode 0x0D zero-extends immediate bits [15:0], ORs it with rs and writes the result to rt, so an immediate of 0x8000 yields 0x00008000.
- R5: Opcode 0x23 drives `dmem_addr` with rs plus the sign-extended immediate, so an immediate of 0xFFFC subtracts 4. It writes `dmem_rdata` into rt at the next edge.
- R6: Opcode 0x2B drives `dmem_we` high, `dmem_addr` with rs plus the sign-extended immediate, and `dmem_wdata` with rt. The memory word takes that value at the edge.
- R7: Opcode 0x04 compares rs and rt. When they are equal, the next `imem_addr` is PC+4 plus the sign-extended immediate shifted left by two, and negative offsets branch backward. Otherwise the next address is PC+4.
- R8: Register 0 always reads as zero, and writes to it have no effect.
- R9: An unrecognised opcode, or an unrecognised funct under opcode 0x00, writes no register and no memory word, and advances the PC by 4.
- R10: `dmem_we` is low for every instruction other than a store.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| imem_addr | output | 32 | Byte address of the current instruction (program counter) |
| imem_data | input | 32 | Instruction word returned combinationally |
| dmem_addr | output | 32 | Byte address for a load or store |
| dmem_wdata | output | 32 | Store data (register rt) |
| dmem_we | output | 1 | Data memory write strobe for the current cycle |
| dmem_rdata | input | 32 | Load data returned combinationally |

## Verification
Within one cycle, a single instruction reads the register file and writes it at the closing edge. The risky overlap is a value that was written at one edge and is read by the next instruction, which can be a store, a load address or a branch compare. The program chains each result straight into the following instruction, including a store of a word just loaded. It also runs a branch whose equality depends on a register that a no-op tried and failed to overwrite. The bench judges the outcome by the store data and addresses seen at the ports, and by the sequence of fetch addresses, which must follow the expected branch path.

// File: rtl/sc_pkg.sv
package sc_pkg;

    localparam int unsigned XLEN    = 32;
    localparam int unsigned NREGS   = 32;
    localparam int unsigned RIDX_W  = $clog2(NREGS);
    localparam int unsigned IMM_W   = 16;

    typedef enum logic [5:0] {
        OPC_REG  = 6'h00,
        OPC_BEQ  = 6'h04,
        OPC_ORI  = 6'h0D,
        OPC_LOAD = 6'h23,
        OPC_STOR = 6'h2B
    } opcode_e;

    typedef enum logic [5:0] {
        FN_ADD = 6'h20,
        FN_SUB = 6'h22,
        FN_AND = 6'h24
    } funct_e;

    typedef enum logic [1:0] {
        ALU_ADD,
        ALU_SUB,
        ALU_AND,
        ALU_OR
    } alu_op_e;

    // Instruction word split into its fixed fields.
    typedef struct packed {
        logic [5:0]        op;
        logic [RIDX_W-1:0] rs;
        logic [RIDX_W-1:0] rt;
        logic [RIDX_W-1:0] rd;
        logic [4:0]        shamt;
        logic [5:0]        funct;
    } insn_t;

    // Control word produced by the decoder.
    typedef struct packed {
        logic    reg_wr;
        logic    dst_is_rd;
        logic    ext_sign;
        logic    alu_imm;
        logic    mem_wr;
        logic    wb_from_mem;
        logic    is_branch;
        alu_op_e alu_op;
    } ctrl_t;

    localparam ctrl_t CTRL_NOP = '{
        reg_wr: 1'b0, dst_is_rd: 1'b0, ext_sign: 1'b0, alu_imm: 1'b0,
        mem_wr: 1'b0, wb_from_mem: 1'b0, is_branch: 1'b0, alu_op: ALU_ADD
    };

    function automatic logic [XLEN-1:0] extend_imm(
        input logic [IMM_W-1:0] imm,
        input logic             sign
    );
        logic fill;
        fill = sign & imm[IMM_W-1];
        return {{(XLEN-IMM_W){fill}}, imm};
    endfunction

    function automatic logic [XLEN-1:0] word_offset(input logic [XLEN-1:0] ext);
        return {ext[XLEN-3:0], 2'b00};
    endfunction

endpackage

// File: rtl/sc_decode.sv
module sc_decode
    import sc_pkg::*;
(
    input  logic [5:0] op,
    input  logic [5:0] funct,
    output ctrl_t      ctrl
);

    always_comb begin
        ctrl = CTRL_NOP;
        unique case (op)
            OPC_REG: begin
                ctrl.dst_is_rd = 1'b1;
                unique case (funct)
                    FN_ADD: begin ctrl.reg_wr = 1'b1; ctrl.alu_op = ALU_ADD; end
                    FN_SUB: begin ctrl.reg_wr = 1'b1; ctrl.alu_op = ALU_SUB; end
                    FN_AND: begin ctrl.reg_wr = 1'b1; ctrl.alu_op = ALU_AND; end
                    default: ctrl.reg_wr = 1'b0;
                endcase
            end
            OPC_ORI: begin
                ctrl.reg_wr  = 1'b1;
                ctrl.alu_imm = 1'b1;
                ctrl.alu_op  = ALU_OR;
            end
            OPC_LOAD: begin
                ctrl.reg_wr      = 1'b1;
                ctrl.ext_sign    = 1'b1;
                ctrl.alu_imm     = 1'b1;
                ctrl.wb_from_mem = 1'b1;
                ctrl.alu_op      = ALU_ADD;
            end
            OPC_STOR: begin
                ctrl.mem_wr   = 1'b1;
                ctrl.ext_sign = 1'b1;
                ctrl.alu_imm  = 1'b1;
                ctrl.alu_op   = ALU_ADD;
            end
            OPC_BEQ: begin
                ctrl.is_branch = 1'b1;
                ctrl.ext_sign  = 1'b1;
                ctrl.alu_op    = ALU_SUB;
            end
            default: ctrl = CTRL_NOP;
        endcase
    end

endmodule

// File: rtl/sc_regfile.sv
module sc_regfile #(
    parameter int unsigned W   = 32,
    parameter int unsigned N   = 32,
    parameter int unsigned NRP = 2,
    localparam int unsigned AW = $clog2(N)
) (
    input  logic                   clk,
    input  logic [NRP-1:0][AW-1:0] raddr,
    output logic [NRP-1:0][W-1:0]  rdata,
    input  logic                   we,
    input  logic [AW-1:0]          waddr,
    input  logic [W-1:0]           wdata
);

    logic [W-1:0] regs [N];

    // Entry 0 is never stored; reads of it are forced to zero below.
    always_ff @(posedge clk) begin
        if (we && waddr != '0) begin
            regs[waddr] <= wdata;
        end
    end

    for (genvar g = 0; g < NRP; g++) begin : g_rport
        assign rdata[g] = (raddr[g] == '0) ? '0 : regs[raddr[g]];
    end

endmodule

// File: rtl/sc_alu.sv
module sc_alu
    import sc_pkg::*;
#(
    parameter int unsigned W = 32
) (
    input  alu_op_e      op,
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] y,
    output logic         eq
);

    always_comb begin
        unique case (op)
            ALU_ADD: y = a + b;
            ALU_SUB: y = a - b;
            ALU_AND: y = a & b;
            ALU_OR:  y = a | b;
            default: y = '0;
        endcase
    end

    assign eq = (a == b);

endmodule

// File: rtl/sc_core.sv
module sc_core
    import sc_pkg::*;
#(
    parameter logic [31:0] RESET_PC = 32'h0
) (
    input  logic        clk,
    input  logic        rst,
    output logic [31:0] imem_addr,
    input  logic [31:0] imem_data,
    output logic [31:0] dmem_addr,
    output logic [31:0] dmem_wdata,
    output logic        dmem_we,
    input  logic [31:0] dmem_rdata
);

    logic [XLEN-1:0] pc_q;
    logic [XLEN-1:0] pc_plus4;
    logic [XLEN-1:0] pc_next;
    insn_t           insn;
    ctrl_t           ctrl;
    logic [XLEN-1:0] imm_ext;
    logic [XLEN-1:0] rs_val;
    logic [XLEN-1:0] rt_val;
    logic [XLEN-1:0] alu_b;
    logic [XLEN-1:0] alu_y;
    logic            ops_equal;
    logic [XLEN-1:0] wb_data;
    logic [RIDX_W-1:0] wb_addr;

    logic [1:0][RIDX_W-1:0] rf_raddr;
    logic [1:0][XLEN-1:0]   rf_rdata;

    assign insn = insn_t'(imem_data);

    sc_decode u_decode (
        .op    (insn.op),
        .funct (insn.funct),
        .ctrl  (ctrl)
    );

    assign rf_raddr[0] = insn.rs;
    assign rf_raddr[1] = insn.rt;
    assign rs_val      = rf_rdata[0];
    assign rt_val      = rf_rdata[1];

    sc_regfile #(
        .W   (XLEN),
        .N   (NREGS),
        .NRP (2)
    ) u_regfile (
        .clk   (clk),
        .raddr (rf_raddr),
        .rdata (rf_rdata),
        .we    (ctrl.reg_wr),
        .waddr (wb_addr),
        .wdata (wb_data)
    );

    assign imm_ext = extend_imm(imem_data[IMM_W-1:0], ctrl.ext_sign);
    assign alu_b   = ctrl.alu_imm ? imm_ext : rt_val;

    sc_alu #(
        .W (XLEN)
    ) u_alu (
        .op (ctrl.alu_op),
        .a  (rs_val),
        .b  (alu_b),
        .y  (alu_y),
        .eq (ops_equal)
    );

    assign wb_addr = ctrl.dst_is_rd ? insn.rd : insn.rt;
    assign wb_data = ctrl.wb_from_mem ? dmem_rdata : alu_y;

    assign dmem_addr  = alu_y;
    assign dmem_wdata = rt_val;
    assign dmem_we    = ctrl.mem_wr;

    assign pc_plus4 = pc_q + XLEN'(4);
    assign pc_next  = (ctrl.is_branch && ops_equal)
                    ? pc_plus4 + word_offset(imm_ext)
                    : pc_plus4;

    always_ff @(posedge clk) begin
        if (rst) begin
            pc_q <= RESET_PC;
        end else begin
            pc_q <= pc_next;
        end
    end

    assign imem_addr = pc_q;

endmodule

// File: rtl/sc_core_chk.sv
module sc_core_chk (
    input logic        clk,
    input logic        rst,
    input logic [31:0] imem_addr,
    input logic [31:0] imem_data,
    input logic        dmem_we,
    input logic [31:0] rs_val
);

    logic [5:0]  opc;
    logic [31:0] br_off;
    logic        known_op;

    assign opc      = imem_data[31:26];
    assign br_off   = {{14{imem_data[15]}}, imem_data[15:0], 2'b00};
    assign known_op = (opc == 6'h00) || (opc == 6'h04) || (opc == 6'h0D)
                   || (opc == 6'h23) || (opc == 6'h2B);

    p_reset_pc_r1: assert property (@(posedge clk) rst |=> imem_addr == 32'h0);

    p_seq_pc_r2: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(opc) != 6'h04) |-> imem_addr == $past(imem_addr) + 32'd4);

    p_branch_pc_r7: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(opc) == 6'h04) |->
        (imem_addr == $past(imem_addr) + 32'd4) ||
        (imem_addr == $past(imem_addr) + 32'd4 + $past(br_off)));

    p_store_we_r6: assert property (@(posedge clk) disable iff (rst)
        (opc == 6'h2B) |-> dmem_we);

    p_we_only_store_r10: assert property (@(posedge clk) disable iff (rst)
        dmem_we |-> (opc == 6'h2B));

    p_unknown_quiet_r9: assert property (@(posedge clk) disable iff (rst)
        !known_op |-> !dmem_we);

    p_zero_reg_r8: assert property (@(posedge clk) disable iff (rst)
        (imem_data[25:21] == 5'd0) |-> rs_val == 32'h0);

endmodule

bind sc_core sc_core_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .imem_addr (imem_addr),
    .imem_data (imem_data),
    .dmem_we   (dmem_we),
    .rs_val    (rs_val)
);

// File: tb/tb_sc_core.sv
module tb_sc_core;

    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 26;

    typedef struct packed {
        logic [7:0]  rq;    // requirement number for the message
        logic [7:0]  pcw;   // expected word index of the fetch address
        logic        we;    // expected store strobe
        logic        ca;    // compare address even without a store
        logic [31:0] a;
        logic [31:0] d;
    } vec_t;

    // Expected trace, one row per executed instruction.
    localparam vec_t VT [NVEC] = '{
        '{8'd1,  8'd0,  1'b0, 1'b0, 32'h0,  32'h0},         // R1 fetch 0 after reset, ORI r1
        '{8'd2,  8'd1,  1'b0, 1'b0, 32'h0,  32'h0},         // R2 ORI r2
        '{8'd2,  8'd2,  1'b0, 1'b0, 32'h0,  32'h0},         // R2 ADD r3
        '{8'd3,  8'd3,  1'b1, 1'b1, 32'h0,  32'h00008005},  // R3 R4 add of zero-extended
        '{8'd2,  8'd4,  1'b0, 1'b0, 32'h0,  32'h0},         // SUB r4
        '{8'd3,  8'd5,  1'b1, 1'b1, 32'h4,  32'hFFFF8005},  // R3 sub
        '{8'd10, 8'd6,  1'b0, 1'b0, 32'h0,  32'h0},         // R10 AND no strobe
        '{8'd3,  8'd7,  1'b1, 1'b1, 32'h10, 32'h00008005},  // R3 and
        '{8'd10, 8'd8,  1'b0, 1'b0, 32'h0,  32'h0},         // ORI to r0
        '{8'd8,  8'd9,  1'b1, 1'b1, 32'h14, 32'h0},         // R8 r0 still zero
        '{8'd5,  8'd10, 1'b0, 1'b1, 32'h0,  32'h0},         // R5 load addr
        '{8'd2,  8'd11, 1'b0, 1'b0, 32'h0,  32'h0},
        '{8'd5,  8'd12, 1'b0, 1'b1, 32'h1C, 32'h0},         // R5 negative offset
        '{8'd5,  8'd13, 1'b1, 1'b1, 32'h18, 32'hCAFEF00D},  // R5 loaded value
        '{8'd6,  8'd14, 1'b1, 1'b1, 32'h24, 32'h00008005},  // R6 store of loaded word
        '{8'd9,  8'd15, 1'b0, 1'b0, 32'h0,  32'h0},         // R9 bad opcode
        '{8'd9,  8'd16, 1'b0, 1'b0, 32'h0,  32'h0},         // R9 bad funct
        '{8'd9,  8'd17, 1'b1, 1'b1, 32'h28, 32'h00008005},  // R9 r6 untouched
        '{8'd7,  8'd18, 1'b0, 1'b0, 32'h0,  32'h0},         // R7 BEQ not taken
        '{8'd7,  8'd19, 1'b0, 1'b0, 32'h0,  32'h0},         // R7 BEQ taken +2
        '{8'd7,  8'd22, 1'b0, 1'b0, 32'h0,  32'h0},         // R7 BEQ +1
        '{8'd7,  8'd24, 1'b0, 1'b0, 32'h0,  32'h0},         // R7 BEQ -2 backward
        '{8'd7,  8'd23, 1'b0, 1'b0, 32'h0,  32'h0},         // R7 BEQ +2
        '{8'd7,  8'd26, 1'b1, 1'b1, 32'h30, 32'h5},         // R6 store after branches
        '{8'd7,  8'd27, 1'b0, 1'b0, 32'h0,  32'h0},         // R7 self loop
        '{8'd7,  8'd27, 1'b0, 1'b0, 32'h0,  32'h0}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] imem_addr;
    logic [31:0] imem_data;
    logic [31:0] dmem_addr;
    logic [31:0] dmem_wdata;
    logic        dmem_we;
    logic [31:0] dmem_rdata;

    logic [31:0] imem [32];
    logic [31:0] dmem [64];

    int  checks = 0;
    int  errors = 0;
    bit  done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sc_core dut (
        .clk        (clk),
        .rst        (rst),
        .imem_addr  (imem_addr),
        .imem_data  (imem_data),
        .dmem_addr  (dmem_addr),
        .dmem_wdata (dmem_wdata),
        .dmem_we    (dmem_we),
        .dmem_rdata (dmem_rdata)
    );

    assign imem_data  = imem[imem_addr[6:2]];
    assign dmem_rdata = dmem[dmem_addr[7:2]];

    always @(posedge clk) begin
        if (dmem_we) dmem[dmem_addr[7:2]] <= dmem_wdata;
    end

    function automatic logic [31:0] rop(input int rs, input int rt, input int rd,
                                        input logic [5:0] fn);
        return {6'h00, 5'(rs), 5'(rt), 5'(rd), 5'd0, fn};
    endfunction

    function automatic logic [31:0] iop(input logic [5:0] op, input int rs,
                                        input int rt, input logic [15:0] imm);
        return {op, 5'(rs), 5'(rt), imm};
    endfunction

    task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", rq, act, exp);
        end
    endtask

    initial begin
        for (int i = 0; i < 32; i++) imem[i] = iop(6'h04, 0, 0, 16'hFFFF);
        for (int i = 0; i < 64; i++) dmem[i] = 32'h0;
        dmem[7] = 32'hCAFEF00D;
        imem[0]  = iop(6'h0D, 0, 1, 16'h8000);      // R4 r1 = 0x00008000
        imem[1]  = iop(6'h0D, 0, 2, 16'h0005);      // r2 = 5
        imem[2]  = rop(1, 2, 3, 6'h20);             // R3 r3 = r1 + r2
        imem[3]  = iop(6'h2B, 0, 3, 16'h0000);
        imem[4]  = rop(2, 1, 4, 6'h22);             // r4 = r2 - r1
        imem[5]  = iop(6'h2B, 0, 4, 16'h0004);
        imem[6]  = rop(3, 4, 5, 6'h24);             // r5 = r3 & r4
        imem[7]  = iop(6'h2B, 0, 5, 16'h0010);
        imem[8]  = iop(6'h0D, 0, 0, 16'h1234);      // R8 write r0
        imem[9]  = iop(6'h2B, 0, 0, 16'h0014);
        imem[10] = iop(6'h23, 0, 6, 16'h0000);      // R5 r6 = mem[0]
        imem[11] = iop(6'h0D, 0, 7, 16'h0020);
        imem[12] = iop(6'h23, 7, 8, 16'hFFFC);      // r8 = mem[0x1C]
        imem[13] = iop(6'h2B, 0, 8, 16'h0018);
        imem[14] = iop(6'h2B, 0, 6, 16'h0024);
        imem[15] = iop(6'h3F, 0, 6, 16'hFFFF);      // R9 unknown opcode
        imem[16] = rop(1, 2, 6, 6'h25);             // R9 unknown funct
        imem[17] = iop(6'h2B, 0, 6, 16'h0028);
        imem[18] = iop(6'h04, 2, 1, 16'h0005);      // not equal
        imem[19] = iop(6'h04, 6, 3, 16'h0002);      // equal, to 22
        imem[20] = iop(6'h2B, 0, 1, 16'h002C);
        imem[21] = iop(6'h2B, 0, 1, 16'h002C);
        imem[22] = iop(6'h04, 0, 0, 16'h0001);      // to 24
        imem[23] = iop(6'h04, 0, 0, 16'h0002);      // to 26
        imem[24] = iop(6'h04, 0, 0, 16'hFFFE);      // back to 23
        imem[25] = iop(6'h2B, 0, 1, 16'h002C);
        imem[26] = iop(6'h2B, 0, 2, 16'h0030);
        imem[27] = iop(6'h04, 0, 0, 16'hFFFF);      // self loop

        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;
        for (int i = 0; i < NVEC; i++) begin
            string tag;
            tag = $sformatf("R%0d", VT[i].rq);
            chk({tag, " fetch"}, imem_addr, {22'd0, VT[i].pcw, 2'b00});
            chk({tag, " R10 strobe"}, {31'd0, dmem_we}, {31'd0, VT[i].we});
            if (VT[i].ca) chk({tag, " addr"}, dmem_addr, VT[i].a);
            if (VT[i].we) chk({tag, " data"}, dmem_wdata, VT[i].d);
            @(negedge clk);
            #1;
        end

        // Memory contents written by the program.
        chk("R6 mem[0x00]", dmem[0], 32'h00008005);
        chk("R3 mem[0x04]", dmem[1], 32'hFFFF8005);
        chk("R3 mem[0x10]", dmem[4], 32'h00008005);
        chk("R8 mem[0x14]", dmem[5], 32'h0);
        chk("R5 mem[0x18]", dmem[6], 32'hCAFEF00D);
        chk("R9 mem[0x28]", dmem[10], 32'h00008005);
        chk("R7 mem[0x2C] skipped", dmem[11], 32'h0);
        chk("R7 mem[0x30]", dmem[12], 32'h5);

        // Reset in the middle of the self loop.
        rst = 1'b1;
        @(negedge clk);
        #1;
        chk("R1 reset fetch", imem_addr, 32'h0);
        @(negedge clk);
        #1;
        chk("R1 reset held", imem_addr, 32'h0);
        rst = 1'b0;
        @(negedge clk);
        #1;
        chk("R2 after reset", imem_addr, 32'h4);

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 5000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule